// File: doc/BRIEF.md
# Dual-Rail Two-Bit Storage Variable

This block keeps a small value, two bits by default, that arrives on a four-phase dual-rail write channel, and makes it available on independent read channels. Every bit travels on a pair of rails: a true rail and a false rail. A pair holding exactly one high rail carries a value. A pair with both rails low is the spacer that separates successive values. The write channel is passive. A producer pushes a complete codeword, the block captures it, raises a per-bit ready indication and then the write acknowledge. The producer then returns every pair to spacer, and the block lowers the ready indications first and the acknowledge after them.

Each read channel is passive and pull-style. A reader raises its request and gets the stored bits on its own rail pairs. It lowers the request and gets the spacer back. All rails and handshake wires are modelled as level signals that are sampled on a common clock.

The write controller is a four-state machine:

- IDLE waits for a complete codeword.
- CAPTURE holds the ready indications high while the acknowledge is still low.
- HELD keeps ready and acknowledge high until the input returns to all-spacer.
- RELEASE keeps the acknowledge high with ready low.

Its transitions are:

- IDLE to CAPTURE when every pair is valid and no read is active.
- CAPTURE to HELD unconditionally.
- HELD to RELEASE when all pairs show spacer.
- RELEASE to IDLE unconditionally.

Each read port is a two-state machine, SPACER and DRIVE. It takes SPACER to DRIVE when its request is high and DRIVE to SPACER when its request is low. Wider variables are built by tiling copies of this block across bits and ports.

Top module: `dr_var2`

## Requirements
- R1: Bit i uses wr_t[i]/wr_f[i]. Logic 1 is (1,0), logic 0 is (0,1) and spacer is (0,0). Read rails never show (1,1) on any pair.
- R2: In IDLE, if every input pair is valid and no read is active at a clock edge, the value is captured at that edge and all bit_rdy bits are high after it with wr_ack low. wr_ack rises one edge later.
- R3: While wr_ack is high, once all pairs read spacer at an edge, bit_rdy is all low after that edge with wr_ack still high. wr_ack falls one edge later.
- R4: While any input pair holds spacer, bit_rdy and wr_ack stay low and nothing is captured.
- R5: A read request seen at an edge drives the stored value on that port's rails after the edge. A low request drives spacer after the edge.
- R6: The read ports act independently. One port may drive while another holds spacer, and both may drive at once.
- R7: A (1,1) input pair is illegal. wr_err is high in the cycle after such an edge, no capture takes place, and bit_rdy stays low.
- R8: After reset, bit_rdy, wr_ack and wr_err are low, all read rails are spacer, and a read returns logic 0 on every bit.
- R9: A write cannot start while any read request is high or any read port is still driving. The port must have returned to spacer at an edge before the capture edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_t | input | BITS | Write true rails |
| wr_f | input | BITS | Write false rails |
| bit_rdy | output | BITS | Per-bit capture ready |
| wr_ack | output | 1 | Write acknowledge |
| wr_err | output | 1 | Illegal input codeword seen in the previous cycle |
| rd_req | input | PORTS | Read request per port |
| rd_t | output | PORTS*BITS | Read true rails, port p bit i at p*BITS+i |
| rd_f | output | PORTS*BITS | Read false rails, same layout |

## Verification
The bench builds the block with its defaults, BITS=2 and PORTS=2. With these values every two-bit value can be written, and both read ports can be overlapped and staggered. A (1,1) pair can be placed next to a spacer or next to a valid pair. A write can also be held off by a read that is still driving.

// File: rtl/dr_var_pkg.sv
package dr_var_pkg;
    typedef enum logic [1:0] {
        W_IDLE    = 2'd0,
        W_CAPTURE = 2'd1,
        W_HELD    = 2'd2,
        W_RELEASE = 2'd3
    } wstate_t;

    typedef enum logic {
        R_SPACER = 1'b0,
        R_DRIVE  = 1'b1
    } rstate_t;
endpackage

// File: rtl/dr_var_write_ctrl.sv
module dr_var_write_ctrl
    import dr_var_pkg::*;
#(
    parameter int BITS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [BITS-1:0] in_t,
    input  logic [BITS-1:0] in_f,
    input  logic            reads_idle,
    output logic [BITS-1:0] store,
    output logic [BITS-1:0] bit_rdy,
    output logic            ack,
    output logic            err
);
    wstate_t st, nxt;
    logic all_valid, all_space, any_bad;

    assign all_valid = &(in_t ^ in_f);
    assign all_space = ~|(in_t | in_f);
    assign any_bad   = |(in_t & in_f);

    always_ff @(posedge clk) begin
        if (!rst_n) st <= W_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            W_IDLE:    if (all_valid && reads_idle) nxt = W_CAPTURE;
            W_CAPTURE: nxt = W_HELD;
            W_HELD:    if (all_space) nxt = W_RELEASE;
            W_RELEASE: nxt = W_IDLE;
            default:   nxt = W_IDLE;
        endcase
    end

    always_comb begin
        bit_rdy = '0;
        ack     = 1'b0;
        unique case (st)
            W_IDLE:    ;
            W_CAPTURE: bit_rdy = '1;
            W_HELD:    begin bit_rdy = '1; ack = 1'b1; end
            W_RELEASE: ack = 1'b1;
            default:   ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store <= '0;
            err   <= 1'b0;
        end else begin
            err <= any_bad;
            if (st == W_IDLE && nxt == W_CAPTURE) store <= in_t;
        end
    end

    AST_ACK_AFTER_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> (&bit_rdy && $past(&bit_rdy)));                 // R2
    AST_RDY_FALLS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack) |-> (bit_rdy == '0 && $past(bit_rdy == '0)));       // R3
    AST_STORE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st != W_IDLE) |=> $stable(store));                            // R2
    AST_NO_WRITE_DURING_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (st == W_IDLE && !reads_idle) |=> (bit_rdy == '0));            // R9
    AST_BAD_NOT_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        (st == W_IDLE && any_bad) |=> (bit_rdy == '0));                // R7
endmodule

// File: rtl/dr_var_read_port.sv
module dr_var_read_port
    import dr_var_pkg::*;
#(
    parameter int BITS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic [BITS-1:0] value,
    output logic [BITS-1:0] o_t,
    output logic [BITS-1:0] o_f,
    output logic            idle
);
    rstate_t st, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= R_SPACER;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            R_SPACER: if (req)  nxt = R_DRIVE;
            R_DRIVE:  if (!req) nxt = R_SPACER;
            default:  nxt = R_SPACER;
        endcase
    end

    always_comb begin
        o_t  = '0;
        o_f  = '0;
        idle = 1'b0;
        unique case (st)
            R_SPACER: idle = 1'b1;
            R_DRIVE:  begin o_t = value; o_f = ~value; end
            default:  idle = 1'b1;
        endcase
    end

    AST_RD_SPACER: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> (o_t == '0 && o_f == '0));                            // R5
    AST_RD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> (&(o_t ^ o_f)));                                       // R5
    AST_RD_NO_DOUBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (o_t & o_f) == '0);                                            // R1
endmodule

// File: rtl/dr_var2.sv
module dr_var2 #(
    parameter int BITS  = 2,
    parameter int PORTS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [BITS-1:0]       wr_t,
    input  logic [BITS-1:0]       wr_f,
    output logic [BITS-1:0]       bit_rdy,
    output logic                  wr_ack,
    output logic                  wr_err,
    input  logic [PORTS-1:0]      rd_req,
    output logic [PORTS*BITS-1:0] rd_t,
    output logic [PORTS*BITS-1:0] rd_f
);
    localparam int RW = PORTS * BITS;

    logic [BITS-1:0]  store;
    logic [PORTS-1:0] port_idle;
    logic             reads_idle;

    assign reads_idle = (&port_idle) && (rd_req == '0);

    dr_var_write_ctrl #(.BITS(BITS)) u_wr (
        .clk(clk), .rst_n(rst_n), .in_t(wr_t), .in_f(wr_f),
        .reads_idle(reads_idle), .store(store), .bit_rdy(bit_rdy),
        .ack(wr_ack), .err(wr_err)
    );

    for (genvar p = 0; p < PORTS; p++) begin : g_rd
        dr_var_read_port #(.BITS(BITS)) u_rd (
            .clk(clk), .rst_n(rst_n), .req(rd_req[p]), .value(store),
            .o_t(rd_t[p*BITS +: BITS]), .o_f(rd_f[p*BITS +: BITS]),
            .idle(port_idle[p])
        );
    end

    AST_RAILS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_t & rd_f) == RW'(0));                                      // R1
endmodule

// File: tb/dr_var2_test.sv
module dr_var2_test;
    localparam int CLK_PERIOD = 10;
    localparam int BITS = 2;
    localparam int PORTS = 2;

    logic clk = 0;
    logic rst_n = 0;
    logic [BITS-1:0] wr_t = '0, wr_f = '0;
    logic [PORTS-1:0] rd_req = '0;
    logic [BITS-1:0] bit_rdy;
    logic wr_ack, wr_err;
    logic [PORTS*BITS-1:0] rd_t, rd_f;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    dr_var2 #(.BITS(BITS), .PORTS(PORTS)) uut (
        .clk(clk), .rst_n(rst_n), .wr_t(wr_t), .wr_f(wr_f),
        .bit_rdy(bit_rdy), .wr_ack(wr_ack), .wr_err(wr_err),
        .rd_req(rd_req), .rd_t(rd_t), .rd_f(rd_f)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) tick();
        rst_n = 1;
        tick();
        chk(bit_rdy == 0 && !wr_ack && !wr_err, "R8", {bit_rdy, wr_ack, wr_err}, 8'h0);
        chk(rd_t == 0 && rd_f == 0, "R8", {rd_t, rd_f}, 8'h0);
        rd_req = 2'b11;
        tick();
        chk(rd_t == 4'b0000 && rd_f == 4'b1111, "R8", {rd_t, rd_f}, 8'h0f);
        rd_req = 2'b00;
        tick();
        chk(rd_t == 0 && rd_f == 0, "R5", {rd_t, rd_f}, 8'h0);
    endtask

    task automatic t_write(input logic [BITS-1:0] v);
        wr_t = v; wr_f = ~v;
        tick();
        chk(bit_rdy == 2'b11 && !wr_ack, "R2", {bit_rdy, wr_ack}, 8'h6);
        tick();
        chk(bit_rdy == 2'b11 && wr_ack, "R2", {bit_rdy, wr_ack}, 8'h7);
        tick();
        chk(bit_rdy == 2'b11 && wr_ack, "R3", {bit_rdy, wr_ack}, 8'h7);
        wr_t = '0; wr_f = '0;
        tick();
        chk(bit_rdy == 0 && wr_ack, "R3", {bit_rdy, wr_ack}, 8'h1);
        tick();
        chk(bit_rdy == 0 && !wr_ack, "R3", {bit_rdy, wr_ack}, 8'h0);
        rd_req = 2'b01;
        tick();
        chk(rd_t[1:0] == v && rd_f[1:0] == ~v, "R5", {rd_t[1:0], rd_f[1:0]}, {v, ~v});
        rd_req = 2'b00;
        tick();
        chk(rd_t == 0 && rd_f == 0, "R5", {rd_t, rd_f}, 8'h0);
    endtask

    task automatic t_partial();
        wr_t = 2'b01; wr_f = 2'b00;
        repeat (2) tick();
        chk(bit_rdy == 0 && !wr_ack, "R4", {bit_rdy, wr_ack}, 8'h0);
        wr_t = 2'b00; wr_f = 2'b10;
        repeat (2) tick();
        chk(bit_rdy == 0 && !wr_ack, "R4", {bit_rdy, wr_ack}, 8'h0);
        wr_t = '0; wr_f = '0;
        tick();
    endtask

    task automatic t_read_both(input logic [BITS-1:0] v);
        rd_req = 2'b10;
        tick();
        chk(rd_t == {v, 2'b00} && rd_f == {~v, 2'b00}, "R6", {rd_t, rd_f}, {v, 2'b00, ~v, 2'b00});
        rd_req = 2'b11;
        tick();
        chk(rd_t == {v, v} && rd_f == {~v, ~v}, "R6", {rd_t, rd_f}, {v, v, ~v, ~v});
        rd_req = 2'b01;
        tick();
        chk(rd_t == {2'b00, v} && rd_f == {2'b00, ~v}, "R6", {rd_t, rd_f}, {2'b00, v, 2'b00, ~v});
        rd_req = 2'b00;
        tick();
        chk(rd_t == 0 && rd_f == 0, "R1", {rd_t, rd_f}, 8'h0);
    endtask

    task automatic t_illegal(input logic [BITS-1:0] prev);
        wr_t = 2'b01; wr_f = 2'b01;
        tick();
        chk(wr_err && bit_rdy == 0, "R7", {bit_rdy, wr_err}, 8'h1);
        wr_t = 2'b11; wr_f = 2'b01;
        tick();
        chk(wr_err && bit_rdy == 0 && !wr_ack, "R7", {bit_rdy, wr_ack, wr_err}, 8'h1);
        wr_t = '0; wr_f = '0;
        tick();
        chk(!wr_err, "R7", {7'b0, wr_err}, 8'h0);
        rd_req = 2'b01;
        tick();
        chk(rd_t[1:0] == prev && rd_f[1:0] == ~prev, "R7", {rd_t[1:0], rd_f[1:0]}, {prev, ~prev});
        rd_req = 2'b00;
        tick();
    endtask

    task automatic t_blocked(input logic [BITS-1:0] v);
        rd_req = 2'b01;
        tick();
        wr_t = v; wr_f = ~v;
        tick();
        chk(bit_rdy == 0 && !wr_ack, "R9", {bit_rdy, wr_ack}, 8'h0);
        tick();
        chk(bit_rdy == 0 && !wr_ack, "R9", {bit_rdy, wr_ack}, 8'h0);
        rd_req = 2'b00;
        tick();
        chk(bit_rdy == 0 && rd_t == 0 && rd_f == 0, "R9", {bit_rdy, rd_t, rd_f}, 8'h0);
        tick();
        chk(bit_rdy == 2'b11 && !wr_ack, "R9", {bit_rdy, wr_ack}, 8'h6);
        tick();
        chk(wr_ack, "R2", {7'b0, wr_ack}, 8'h1);
        wr_t = '0; wr_f = '0;
        repeat (2) tick();
        chk(!wr_ack && bit_rdy == 0, "R3", {bit_rdy, wr_ack}, 8'h0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_write(2'b10);
        t_write(2'b01);
        t_partial();
        t_read_both(2'b01);
        t_write(2'b11);
        t_illegal(2'b11);
        t_blocked(2'b00);
        t_read_both(2'b00);
        t_write(2'b10);
        t_read_both(2'b10);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule